// File: doc/BRIEF.md
# 8-bit Accumulator Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. It owns an eight-entry register file, with register 0 acting as the accumulator, and an 8-bit flag register. Each accepted operation names a 5-bit operation code, a register index and an 8-bit data operand. In the same clock edge the block writes the result register(s) and the flags.

Operations take an explicit operand, `op_data`, which is the value the decoder fetched for "Rn", and `op_idx`, which selects both the destination register for register-targeted operations and the flag bit for bit operations. Multiply is the only operation that reads a register other than the accumulator from inside the block. It reads R[`op_idx`]. Read ports for one register and for the flags let the surrounding logic, or a bench, observe state.

The operation input is a valid-qualified stream with no ready signal. The unit accepts one operation on every clock edge where `op_valid` is high, so it never applies back-pressure. An upstream stage may hold `op_valid` high for back-to-back operations. Each operation sees the state left by the one before it.

Top module: `acc_alu`

## Requirements
- R1: After reset, all eight registers and the flag register read zero. Flag bits are Z = bit 0, C = bit 1, N = bit 2. Bits 3 to 7 are general-purpose.
- R2: With `op_valid` low, or for code 10000 (IDLE), or for any code not listed in these requirements, no register and no flag changes.
- R3: ADD (01010) sets R0 to R0+d. ADC (00001) sets R0 to R0+d+C. Both set C to the carry out of bit 7, Z when the 8-bit result is zero, and N to result bit 7.
- R4: SBC (01001) sets R0 to R0+~d+C. CMP (01111) computes R0+~d+1, updates only N, C and Z, and writes no register. In both, C is the carry out of bit 7.
- R5: INC (00000) writes d+1 to R[idx], with C set on a wrap from 0xFF. DEC (01000) writes d+0xFF to R[idx], so C is set for every d except 0. Both update Z and N.
- R6: INC with `op_noflags` high updates only C and R[idx]. ADD-CARRY (10010) writes d+C to R[idx] and updates only C. Together they form a 16-bit pair increment.
- R7: ROL (00110) writes {d[6:0],C} to R[idx] with C taking d[7]. ROR (00111) writes {C,d[7:1]} with C taking d[0]. Both update Z and N.
- R8: OR (00011), AND (00100) and XOR (00101) combine R0 with d into R0. TX0 (00010) copies d into R0. T0X (01110) copies R0 into R[idx]. All five update only Z and N.
- R9: STP (01011) sets and CLP (01101) clears flag bit idx. BTT (01100) sets Z to the inverse of R0 bit idx and N to R0 bit 7.
- R10: MUL (10110) writes the low byte of R0*R[idx] to R0 and the high byte to R1. It sets Z exactly when the 16-bit product is zero and leaves the other flags unchanged.
- R11: LDI (11100) writes d to R[idx] and updates Z and N, unless `op_noflags` is high, in which case the flags are unchanged.
- R12: RFLG (10011) replaces the whole flag register with d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle (always accepted) |
| op_code | input | 5 | Operation code |
| op_idx | input | 3 | Register index / flag bit index |
| op_data | input | 8 | Data operand |
| op_noflags | input | 1 | Suppress Z/N for INC and all flags for LDI |
| rd_idx | input | 3 | Register read port index |
| rd_val | output | 8 | Value of R[rd_idx] |
| flags | output | 8 | Flag register |

## Verification
Arithmetic is driven with operands that do and do not carry out of bit 7, and with results that land exactly on zero. This separates carry from zero detection, and it separates the +C forms from the plain forms. Subtraction and compare use both a borrow case and an exact-match case, which shows the not-borrow sense of C and that compare leaves R0 intact. Rotates start from flag patterns where the incoming and outgoing carry differ. The pair increment runs with the Z/N flags preset to show that they survive. Multiply uses small, large and zero products so that the high byte and the 16-bit zero test are each visible.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_INC  = 5'b00000,
    OP_ADC  = 5'b00001,
    OP_TX0  = 5'b00010,
    OP_OR   = 5'b00011,
    OP_AND  = 5'b00100,
    OP_XOR  = 5'b00101,
    OP_ROL  = 5'b00110,
    OP_ROR  = 5'b00111,
    OP_DEC  = 5'b01000,
    OP_SBC  = 5'b01001,
    OP_ADD  = 5'b01010,
    OP_STP  = 5'b01011,
    OP_BTT  = 5'b01100,
    OP_CLP  = 5'b01101,
    OP_T0X  = 5'b01110,
    OP_CMP  = 5'b01111,
    OP_IDLE = 5'b10000,
    OP_ADDC = 5'b10010,
    OP_RFLG = 5'b10011,
    OP_MUL  = 5'b10110,
    OP_LDI  = 5'b11100
  } alu_op_e;

  localparam int FLG_Z = 0;
  localparam int FLG_C = 1;
  localparam int FLG_N = 2;

endpackage

// File: rtl/acc_alu_regs.sv
module acc_alu_regs #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [DW-1:0]    wval,
  input  logic             hi_we,
  input  logic [DW-1:0]    hi_val,
  input  logic [IW-1:0]    ridx_a,
  output logic [DW-1:0]    rdata_a,
  input  logic [IW-1:0]    ridx_b,
  output logic [DW-1:0]    rdata_b,
  output logic [DW-1:0]    acc,
  output logic [NREG*DW-1:0] flat
);

  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (hi_we && g == 1) begin
        q[g] <= hi_val;
      end else if (we && widx == IW'(g)) begin
        q[g] <= wval;
      end
    end
    assign flat[g*DW +: DW] = q[g];
  end

  assign rdata_a = q[ridx_a];
  assign rdata_b = q[ridx_b];
  assign acc     = q[0];

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          valid,
  input  logic [4:0]    code,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] data,
  input  logic          noflags,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rsel,
  input  logic [DW-1:0] flags_q,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_val,
  output logic          hi_en,
  output logic [DW-1:0] hi_val,
  output logic [DW-1:0] flags_d
);

  logic [2*DW-1:0] prod;
  logic [DW:0]     sum;
  logic [DW-1:0]   res;
  logic            cin;

  assign prod   = acc * rsel;
  assign hi_val = prod[2*DW-1:DW];
  assign cin    = flags_q[FLG_C];

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = idx;
    wr_val  = data;
    hi_en   = 1'b0;
    flags_d = flags_q;
    sum     = '0;
    res     = '0;
    if (valid) begin
      case (code)
        OP_INC, OP_DEC, OP_ADDC: begin
          if (code == OP_INC)      sum = {1'b0, data} + (DW+1)'(1);
          else if (code == OP_DEC) sum = {1'b0, data} + {1'b0, {DW{1'b1}}};
          else                     sum = {1'b0, data} + (DW+1)'(cin);
          res = sum[DW-1:0];
          wr_en = 1'b1;
          wr_val = res;
          flags_d[FLG_C] = sum[DW];
          if (code == OP_DEC || (code == OP_INC && !noflags)) begin
            flags_d[FLG_Z] = ~|res;
            flags_d[FLG_N] = res[DW-1];
          end
        end
        OP_ADD, OP_ADC, OP_SBC, OP_CMP: begin
          if (code == OP_ADD)      sum = {1'b0, acc} + {1'b0, data};
          else if (code == OP_ADC) sum = {1'b0, acc} + {1'b0, data} + (DW+1)'(cin);
          else if (code == OP_SBC) sum = {1'b0, acc} + {1'b0, ~data} + (DW+1)'(cin);
          else                     sum = {1'b0, acc} + {1'b0, ~data} + (DW+1)'(1);
          res = sum[DW-1:0];
          wr_en = (code != OP_CMP);
          wr_idx = '0;
          wr_val = res;
          flags_d[FLG_C] = sum[DW];
          flags_d[FLG_Z] = ~|res;
          flags_d[FLG_N] = res[DW-1];
        end
        OP_ROL, OP_ROR: begin
          if (code == OP_ROL) sum = {data, cin};
          else                sum = {data[0], cin, data[DW-1:1]};
          res = sum[DW-1:0];
          wr_en = 1'b1;
          wr_val = res;
          flags_d[FLG_C] = sum[DW];
          flags_d[FLG_Z] = ~|res;
          flags_d[FLG_N] = res[DW-1];
        end
        OP_OR, OP_AND, OP_XOR, OP_TX0, OP_T0X: begin
          case (code)
            OP_OR:   res = acc | data;
            OP_AND:  res = acc & data;
            OP_XOR:  res = acc ^ data;
            OP_TX0:  res = data;
            default: res = acc;
          endcase
          wr_en = 1'b1;
          wr_idx = (code == OP_T0X) ? idx : '0;
          wr_val = res;
          flags_d[FLG_Z] = ~|res;
          flags_d[FLG_N] = res[DW-1];
        end
        OP_STP:  flags_d[idx] = 1'b1;
        OP_CLP:  flags_d[idx] = 1'b0;
        OP_BTT: begin
          flags_d[FLG_Z] = ~acc[idx];
          flags_d[FLG_N] = acc[DW-1];
        end
        OP_MUL: begin
          wr_en = 1'b1;
          wr_idx = '0;
          wr_val = prod[DW-1:0];
          hi_en = 1'b1;
          flags_d[FLG_Z] = ~|prod;
        end
        OP_LDI: begin
          wr_en = 1'b1;
          if (!noflags) begin
            flags_d[FLG_Z] = ~|data;
            flags_d[FLG_N] = data[DW-1];
          end
        end
        OP_RFLG: flags_d = data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic [IW-1:0] op_idx,
  input  logic [DW-1:0] op_data,
  input  logic          op_noflags,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] flags
);

  logic            wr_en, hi_en;
  logic [IW-1:0]   wr_idx;
  logic [DW-1:0]   wr_val, hi_val, rsel, acc, flags_d;
  logic [NREG*DW-1:0] regs_flat;

  acc_alu_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .widx(wr_idx), .wval(wr_val),
    .hi_we(hi_en), .hi_val(hi_val),
    .ridx_a(op_idx), .rdata_a(rsel),
    .ridx_b(rd_idx), .rdata_b(rd_val),
    .acc(acc), .flat(regs_flat)
  );

  acc_alu_exec #(.DW(DW), .NREG(NREG)) u_exec (
    .valid(op_valid), .code(op_code), .idx(op_idx), .data(op_data),
    .noflags(op_noflags), .acc(acc), .rsel(rsel), .flags_q(flags),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .hi_en(hi_en), .hi_val(hi_val), .flags_d(flags_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  // R2: nothing moves without a recognised, valid operation
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code == OP_IDLE) |=> ($stable(regs_flat) && $stable(flags)));

  // R4: compare touches no register
  p_cmp_keeps_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> $stable(regs_flat));

  // R6: silent increment leaves Z and N alone
  p_inc_silent_zn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_INC && op_noflags)
      |=> (flags[FLG_Z] == $past(flags[FLG_Z]) && flags[FLG_N] == $past(flags[FLG_N])));

  // R10: multiply alters no flag other than Z
  p_mul_only_z_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MUL) |=> (flags[DW-1:1] == $past(flags[DW-1:1])));

  // R12: flag restore takes the operand whole
  p_flag_restore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RFLG) |=> (flags == $past(op_data)));

endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

  localparam logic [4:0] C_INC = 5'b00000, C_ADC = 5'b00001, C_TX0 = 5'b00010,
    C_OR = 5'b00011, C_AND = 5'b00100, C_XOR = 5'b00101, C_ROL = 5'b00110,
    C_ROR = 5'b00111, C_DEC = 5'b01000, C_SBC = 5'b01001, C_ADD = 5'b01010,
    C_STP = 5'b01011, C_BTT = 5'b01100, C_CLP = 5'b01101, C_T0X = 5'b01110,
    C_CMP = 5'b01111, C_IDLE = 5'b10000, C_ADDC = 5'b10010, C_RFLG = 5'b10011,
    C_MUL = 5'b10110, C_LDI = 5'b11100, C_BAD = 5'b10001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [2:0] op_idx = '0;
  logic [7:0] op_data = '0;
  logic       op_noflags = 1'b0;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_val, flags;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .op_data(op_data), .op_noflags(op_noflags),
    .rd_idx(rd_idx), .rd_val(rd_val), .flags(flags)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [4:0] c, input logic [2:0] i, input logic [7:0] d,
                       input logic nf = 1'b0, input logic v = 1'b1);
    @(negedge clk);
    op_valid = v; op_code = c; op_idx = i; op_data = d; op_noflags = nf;
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  task automatic reg_is(input string req, input logic [2:0] i, input logic [7:0] exp);
    rd_idx = i;
    #1 chk(req, rd_val, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) reg_is("R1 reg reset", 3'(i), 8'h00);
    chk("R1 flags reset", flags, 8'h00);
  endtask

  task automatic t_add;
    issue(C_LDI, 0, 8'hF0);
    issue(C_ADD, 0, 8'h20);
    reg_is("R3 add carry R0", 0, 8'h10); chk("R3 add carry flags", flags, 8'h02);
    issue(C_ADC, 0, 8'h01);
    reg_is("R3 adc R0", 0, 8'h12); chk("R3 adc flags", flags, 8'h00);
    issue(C_ADD, 0, 8'hEE);
    reg_is("R3 add to zero R0", 0, 8'h00); chk("R3 add to zero flags", flags, 8'h03);
  endtask

  task automatic t_sub;
    issue(C_RFLG, 0, 8'h00);
    issue(C_LDI, 0, 8'h50);
    issue(C_SBC, 0, 8'h10);
    reg_is("R4 sbc borrow-in R0", 0, 8'h3F); chk("R4 sbc flags", flags, 8'h02);
    issue(C_SBC, 0, 8'h3F);
    reg_is("R4 sbc exact R0", 0, 8'h00); chk("R4 sbc exact flags", flags, 8'h03);
    issue(C_LDI, 0, 8'h05);
    issue(C_CMP, 0, 8'h06);
    chk("R4 cmp borrow flags", flags, 8'h04);
    reg_is("R4 cmp keeps R0", 0, 8'h05);
    issue(C_CMP, 0, 8'h05);
    chk("R4 cmp equal flags", flags, 8'h03);
  endtask

  task automatic t_incdec;
    issue(C_RFLG, 0, 8'h00);
    issue(C_INC, 3, 8'hFF);
    reg_is("R5 inc wrap", 3, 8'h00); chk("R5 inc wrap flags", flags, 8'h03);
    issue(C_DEC, 4, 8'h00);
    reg_is("R5 dec from zero", 4, 8'hFF); chk("R5 dec zero flags", flags, 8'h04);
    issue(C_DEC, 4, 8'h01);
    reg_is("R5 dec to zero", 4, 8'h00); chk("R5 dec one flags", flags, 8'h03);
  endtask

  task automatic t_pair;
    issue(C_RFLG, 0, 8'h05);
    issue(C_INC, 2, 8'hFF, 1'b1);
    reg_is("R6 low byte wrap", 2, 8'h00); chk("R6 silent inc flags", flags, 8'h07);
    issue(C_ADDC, 3, 8'h12);
    reg_is("R6 high byte ripple", 3, 8'h13); chk("R6 addc flags", flags, 8'h05);
    issue(C_ADDC, 3, 8'hFF);
    reg_is("R6 addc no carry", 3, 8'hFF); chk("R6 addc no carry flags", flags, 8'h05);
  endtask

  task automatic t_rot;
    issue(C_RFLG, 0, 8'h02);
    issue(C_ROL, 5, 8'h80);
    reg_is("R7 rol", 5, 8'h01); chk("R7 rol flags", flags, 8'h02);
    issue(C_ROR, 6, 8'h01);
    reg_is("R7 ror carry in", 6, 8'h80); chk("R7 ror flags", flags, 8'h06);
    issue(C_RFLG, 0, 8'h00);
    issue(C_ROR, 6, 8'h01);
    reg_is("R7 ror to zero", 6, 8'h00); chk("R7 ror zero flags", flags, 8'h03);
  endtask

  task automatic t_logic;
    issue(C_RFLG, 0, 8'h02);
    issue(C_LDI, 0, 8'hF0);
    issue(C_OR, 0, 8'h0F);
    reg_is("R8 or", 0, 8'hFF); chk("R8 or flags", flags, 8'h06);
    issue(C_AND, 0, 8'h00);
    reg_is("R8 and", 0, 8'h00); chk("R8 and flags", flags, 8'h03);
    issue(C_TX0, 0, 8'h9A);
    issue(C_XOR, 0, 8'h1A);
    reg_is("R8 tx0 then xor", 0, 8'h80); chk("R8 xor flags", flags, 8'h06);
    issue(C_T0X, 7, 8'h00);
    reg_is("R8 t0x copy", 7, 8'h80); chk("R8 t0x flags", flags, 8'h06);
  endtask

  task automatic t_bits;
    issue(C_RFLG, 0, 8'h00);
    issue(C_STP, 6, 8'h00);
    issue(C_STP, 3, 8'h00);
    chk("R9 stp", flags, 8'h48);
    issue(C_CLP, 6, 8'h00);
    chk("R9 clp", flags, 8'h08);
    issue(C_LDI, 0, 8'h84);
    issue(C_BTT, 2, 8'h00);
    chk("R9 btt set bit", flags, 8'h0C);
    issue(C_BTT, 0, 8'h00);
    chk("R9 btt clear bit", flags, 8'h0D);
  endtask

  task automatic t_mul;
    issue(C_RFLG, 0, 8'hF6);
    issue(C_LDI, 0, 8'h0C);
    issue(C_LDI, 5, 8'h15);
    issue(C_MUL, 5, 8'h00);
    reg_is("R10 mul low", 0, 8'hFC); reg_is("R10 mul high", 1, 8'h00);
    chk("R10 mul flags", flags, 8'hF2);
    issue(C_MUL, 5, 8'h00);
    reg_is("R10 mul big low", 0, 8'hAC); reg_is("R10 mul big high", 1, 8'h14);
    issue(C_LDI, 6, 8'h00);
    issue(C_LDI, 0, 8'h07);
    issue(C_MUL, 6, 8'h00);
    reg_is("R10 mul zero low", 0, 8'h00); reg_is("R10 mul zero high", 1, 8'h00);
    chk("R10 mul zero flags", flags, 8'hF3);
  endtask

  task automatic t_ldi;
    issue(C_RFLG, 0, 8'h02);
    issue(C_LDI, 4, 8'h80, 1'b1);
    reg_is("R11 silent load", 4, 8'h80); chk("R11 silent load flags", flags, 8'h02);
    issue(C_LDI, 4, 8'h00);
    reg_is("R11 load zero", 4, 8'h00); chk("R11 load flags", flags, 8'h03);
  endtask

  task automatic t_rflg;
    issue(C_RFLG, 0, 8'hA5);
    chk("R12 restore", flags, 8'hA5);
  endtask

  task automatic t_idle;
    issue(C_LDI, 0, 8'h33);
    issue(C_RFLG, 0, 8'h40);
    issue(C_ADD, 0, 8'hFF, 1'b0, 1'b0);
    reg_is("R2 invalid op R0", 0, 8'h33); chk("R2 invalid op flags", flags, 8'h40);
    issue(C_IDLE, 0, 8'hFF);
    reg_is("R2 idle R0", 0, 8'h33); chk("R2 idle flags", flags, 8'h40);
    issue(C_BAD, 0, 8'hFF);
    reg_is("R2 unlisted R0", 0, 8'h33); chk("R2 unlisted flags", flags, 8'h40);
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_add();
    t_sub();
    t_incdec();
    t_pair();
    t_rot();
    t_logic();
    t_bits();
    t_mul();
    t_ldi();
    t_rflg();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule